// File: doc/BRIEF.md
# PHY Control Register Bank with Set/Clear/Toggle Aliases

This block is a bank of 32-bit control and status registers for a USB PHY, reached over a simple APB-style bus inside a 4 KB window. Most writable registers are followed by three alias words. A write to an alias does not store the data. It ORs the data into the base register, clears the bits given in the data, or inverts them. Software can therefore change single bits without a read-modify-write sequence. A read from any alias returns the base register.

Bit 31 of the control register requests a soft reset. The soft reset reloads the power-down, transmit, receive and control registers with their default values. The status and debug registers keep their contents. Whether a write fires the soft reset depends on the kind of access and, for a toggle, on the value of bit 31 after the toggle. A synchronous active-low reset loads every register. The registers only hold values. They drive no other logic.

Top module: `phy_ctrl_regbank`

## Requirements
- R1: After the hardware reset, reads return the following values. Power-down at 0x000 is 0x001E1C00, transmit at 0x010 is 0x10060607, receive at 0x020 is 0, control at 0x030 is 0xC0200000, status at 0x040 is 0, debug at 0x050 is 0x7F180000, debug0-status at 0x060 is 0, debug1 at 0x070 is 0x00001000 and version at 0x080 is 0x04020000.
- R2: A full-word write to the base address of power-down, transmit, receive, control, status, debug or debug1 stores the data. For control this holds only when data bit 31 is 0.
- R3: Power-down, transmit, receive, control, debug and debug1 each have three aliases after the base address. Base+0x4 ORs the data into the register, base+0x8 clears the bits set in the data, and base+0xC XORs the data into the register. Status has no aliases.
- R4: A read from base+0x4, base+0x8 or base+0xC returns the current value of that base register.
- R5: A write to control at 0x030, or to its OR alias at 0x034, with data bit 31 set fires the soft reset. Power-down, transmit, receive and control then take their R1 values on that same clock edge, and the soft-reset values override the written data.
- R6: A soft reset leaves status, debug and debug1 unchanged.
- R7: A write to the control clear alias at 0x038 never fires the soft reset. A write to the control toggle alias at 0x03C fires it only when data bit 31 is 1 and control bit 31 is 1 after the XOR.
- R8: The words at 0x060 and 0x080 are read-only, and writes to them are ignored. Writes to addresses with no register, including 0x044 and 0x100, are ignored, and reads from them return 0.
- R9: A write is ignored when the byte strobe is not 4'hF or when paddr[1:0] is not 0. A read with paddr[1:0] not 0 returns 0.
- R10: Every access finishes in one access cycle, with pready high and pslverr low. A written value is visible to a read in the next access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Synchronous active-low hardware reset |
| psel | input | 1 | Select for this block |
| penable | input | 1 | Access phase of the transfer |
| pwrite | input | 1 | 1 for a write, 0 for a read |
| paddr | input | 12 | Byte address inside the 4 KB window |
| pwdata | input | 32 | Write data |
| pstrb | input | 4 | Byte strobes. Only 4'hF writes |
| prdata | output | 32 | Read data, valid in the access phase |
| pready | output | 1 | Transfer complete, always high |
| pslverr | output | 1 | Error response, always low |

## Verification
The hardest case to reach is a toggle write that fires the soft reset. The soft-reset default of control already has bit 31 set, so a toggle of bit 31 right after any soft reset clears the bit and must not fire. The stimulus first clears bit 31 through the clear alias and shows that this fires nothing. It then toggles the bit, which must fire. It then loads a marker into power-down and toggles once more, and this time the marker must survive. Reads through the aliases after each step check the base register and the registers the soft reset must leave alone.

// File: rtl/phy_regbank_pkg.sv
// Package: shared widths, slot numbering, access kinds, default values
// and the single function that applies an access kind to a register.
// Assumes a 32-bit data path and word-aligned slots.
package phy_regbank_pkg;

    localparam int DW      = 32;
    localparam int NSLOT   = 7;
    localparam int SRST_BIT = 31;

    // Writable slot numbers; slots 0..3 follow address order (word>>2)
    localparam int SLOT_PWD   = 0;
    localparam int SLOT_TX    = 1;
    localparam int SLOT_RX    = 2;
    localparam int SLOT_CTRL  = 3;
    localparam int SLOT_STAT  = 4;
    localparam int SLOT_DBG   = 5;
    localparam int SLOT_DBG1  = 6;

    // Default values
    localparam logic [DW-1:0] INIT_PWD     = 32'h001E_1C00;
    localparam logic [DW-1:0] INIT_TX      = 32'h1006_0607;
    localparam logic [DW-1:0] INIT_RX      = 32'h0000_0000;
    localparam logic [DW-1:0] INIT_CTRL    = 32'hC020_0000;
    localparam logic [DW-1:0] INIT_STAT    = 32'h0000_0000;
    localparam logic [DW-1:0] INIT_DBG     = 32'h7F18_0000;
    localparam logic [DW-1:0] INIT_DBG1    = 32'h0000_1000;
    localparam logic [DW-1:0] VAL_DBG0ST   = 32'h0000_0000;
    localparam logic [DW-1:0] VAL_VERSION  = 32'h0402_0000;

    // Access kind, equal to the low two bits of the word index
    typedef enum logic [1:0] {
        OP_WRITE = 2'd0,
        OP_SET   = 2'd1,
        OP_CLR   = 2'd2,
        OP_TOG   = 2'd3
    } op_e;

    // Reset value of a writable slot
    function automatic logic [DW-1:0] slot_init(input int s);
        case (s)
            SLOT_PWD:  return INIT_PWD;
            SLOT_TX:   return INIT_TX;
            SLOT_RX:   return INIT_RX;
            SLOT_CTRL: return INIT_CTRL;
            SLOT_STAT: return INIT_STAT;
            SLOT_DBG:  return INIT_DBG;
            default:   return INIT_DBG1;
        endcase
    endfunction

    // 1 when the soft reset reloads the slot
    function automatic bit slot_soft(input int s);
        return (s <= SLOT_CTRL);
    endfunction

    // Result of an access kind applied to a current value
    function automatic logic [DW-1:0] apply_op(input logic [DW-1:0] cur,
                                               input op_e op,
                                               input logic [DW-1:0] d);
        case (op)
            OP_SET:  return cur | d;
            OP_CLR:  return cur & ~d;
            OP_TOG:  return cur ^ d;
            default: return d;
        endcase
    endfunction

endpackage

// File: rtl/phy_addr_decode.sv
// Address decoder: maps a byte address to a writable slot plus access kind,
// or to a read-only constant word. Misaligned addresses decode to nothing.
// Assumes AW >= 8 so that the whole map fits in the window.
module phy_addr_decode
    import phy_regbank_pkg::*;
#(
    parameter int AW = 12
) (
    input  logic [AW-1:0] addr,
    output logic          slot_hit,
    output logic [2:0]    slot_idx,
    output op_e           slot_op,
    output logic          ro_hit,
    output logic [DW-1:0] ro_val
);
    localparam int WW = AW - 2;

    logic [WW-1:0] word;
    logic          aligned;

    assign word    = addr[AW-1:2];
    assign aligned = (addr[1:0] == 2'b00);

    // Decode the word index into slot, access kind and read-only hits
    always_comb begin
        slot_hit = 1'b0;
        slot_idx = 3'd0;
        slot_op  = OP_WRITE;
        ro_hit   = 1'b0;
        ro_val   = '0;
        if (aligned) begin
            if (int'(word) < 32) begin
                case (word[4:2])
                    3'd0, 3'd1, 3'd2, 3'd3: begin
                        slot_hit = 1'b1;
                        slot_idx = word[4:2];
                        slot_op  = op_e'(word[1:0]);
                    end
                    3'd4: begin
                        if (word[1:0] == 2'd0) begin
                            slot_hit = 1'b1;
                            slot_idx = 3'(SLOT_STAT);
                        end
                    end
                    3'd5: begin
                        slot_hit = 1'b1;
                        slot_idx = 3'(SLOT_DBG);
                        slot_op  = op_e'(word[1:0]);
                    end
                    3'd6: begin
                        if (word[1:0] == 2'd0) begin
                            ro_hit = 1'b1;
                            ro_val = VAL_DBG0ST;
                        end
                    end
                    default: begin
                        slot_hit = 1'b1;
                        slot_idx = 3'(SLOT_DBG1);
                        slot_op  = op_e'(word[1:0]);
                    end
                endcase
            end else if (int'(word) == 32) begin
                ro_hit = 1'b1;
                ro_val = VAL_VERSION;
            end
        end
    end
endmodule

// File: rtl/phy_soft_reset_gen.sv
// Soft-reset trigger: decides from the access kind, data bit 31 and the
// present control bit 31 whether an accepted control write fires the
// soft reset. Assumes wr_ctrl is already qualified by strobes and address.
module phy_soft_reset_gen
    import phy_regbank_pkg::*;
(
    input  logic wr_ctrl,
    input  op_e  op,
    input  logic data_msb,
    input  logic ctrl_msb,
    output logic fire
);
    // Direct and OR writes fire on data bit 31; toggle fires only on 0 -> 1
    always_comb begin
        fire = 1'b0;
        if (wr_ctrl && data_msb) begin
            case (op)
                OP_WRITE, OP_SET: fire = 1'b1;
                OP_TOG:           fire = ~ctrl_msb;
                default:          fire = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/phy_bank_reg.sv
// One register of the bank: applies direct, OR, clear and toggle writes,
// and reloads its default on the soft reset when SOFT_EN is set.
// The soft reset wins over a write on the same edge. Synchronous reset.
module phy_bank_reg
    import phy_regbank_pkg::*;
#(
    parameter logic [DW-1:0] INIT_VAL = '0,
    parameter bit            SOFT_EN  = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  op_e           op,
    input  logic [DW-1:0] wdata,
    input  logic          soft_rst,
    output logic [DW-1:0] q
);
    // Register update: hardware reset, then soft reset, then write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= INIT_VAL;
        end else if (SOFT_EN && soft_rst) begin
            q <= INIT_VAL;
        end else if (wr_en) begin
            q <= apply_op(q, op, wdata);
        end
    end
endmodule

// File: rtl/phy_ctrl_regbank.sv
// Top: APB-style register bank for PHY control. Zero-wait accesses,
// combinational read data in the access phase, writes on the access edge.
// Assumes full-word aligned accesses; anything else writes nothing.
module phy_ctrl_regbank
    import phy_regbank_pkg::*;
#(
    parameter int AW = 12
) (
    input  logic          pclk,
    input  logic          presetn,
    input  logic          psel,
    input  logic          penable,
    input  logic          pwrite,
    input  logic [AW-1:0] paddr,
    input  logic [DW-1:0] pwdata,
    input  logic [3:0]    pstrb,
    output logic [DW-1:0] prdata,
    output logic          pready,
    output logic          pslverr
);
    logic                      dec_hit;
    logic [2:0]                dec_slot;
    op_e                       dec_op;
    logic                      dec_ro;
    logic [DW-1:0]             dec_ro_val;
    logic                      wr_acc;
    logic                      soft_fire;
    logic [NSLOT-1:0][DW-1:0]  slot_q;

    phy_addr_decode #(.AW(AW)) i_dec (
        .addr     (paddr),
        .slot_hit (dec_hit),
        .slot_idx (dec_slot),
        .slot_op  (dec_op),
        .ro_hit   (dec_ro),
        .ro_val   (dec_ro_val)
    );

    // Accepted write: access phase, full strobes, decoded writable slot
    assign wr_acc = psel && penable && pwrite && (pstrb == 4'hF) && dec_hit;

    phy_soft_reset_gen i_srst (
        .wr_ctrl  (wr_acc && (dec_slot == 3'(SLOT_CTRL))),
        .op       (dec_op),
        .data_msb (pwdata[SRST_BIT]),
        .ctrl_msb (slot_q[SLOT_CTRL][SRST_BIT]),
        .fire     (soft_fire)
    );

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        phy_bank_reg #(
            .INIT_VAL (slot_init(g)),
            .SOFT_EN  (slot_soft(g))
        ) i_reg (
            .clk      (pclk),
            .rst_n    (presetn),
            .wr_en    (wr_acc && (dec_slot == 3'(g))),
            .op       (dec_op),
            .wdata    (pwdata),
            .soft_rst (soft_fire),
            .q        (slot_q[g])
        );
    end

    // Read mux: aliases read their base slot, unmapped words read zero
    always_comb begin
        prdata = '0;
        if (psel && !pwrite) begin
            if (dec_hit) begin
                prdata = slot_q[dec_slot];
            end else if (dec_ro) begin
                prdata = dec_ro_val;
            end
        end
    end

    assign pready  = 1'b1;
    assign pslverr = 1'b0;
endmodule

// File: rtl/phy_ctrl_regbank_chk.sv
// Checker: watches bus writes and the slot registers and checks the
// alias arithmetic, the soft-reset rules and the ignored writes.
module phy_ctrl_regbank_chk
    import phy_regbank_pkg::*;
#(
    parameter int AW = 12
) (
    input logic                     pclk,
    input logic                     presetn,
    input logic                     psel,
    input logic                     penable,
    input logic                     pwrite,
    input logic [AW-1:0]            paddr,
    input logic [DW-1:0]            pwdata,
    input logic [3:0]               pstrb,
    input logic [NSLOT-1:0][DW-1:0] slot_q
);
    logic acc;
    assign acc = psel && penable && pwrite && (pstrb == 4'hF);

    // R3: OR alias of the transmit register
    assert_set_alias_R3: assert property (@(posedge pclk) disable iff (!presetn)
        acc && paddr == AW'(12'h014) |=>
            slot_q[SLOT_TX] == ($past(slot_q[SLOT_TX]) | $past(pwdata)));

    // R3: clear alias of the receive register
    assert_clr_alias_R3: assert property (@(posedge pclk) disable iff (!presetn)
        acc && paddr == AW'(12'h028) |=>
            slot_q[SLOT_RX] == ($past(slot_q[SLOT_RX]) & ~$past(pwdata)));

    // R5: direct or OR write with bit 31 loads the soft-reset values
    assert_soft_load_R5: assert property (@(posedge pclk) disable iff (!presetn)
        acc && (paddr == AW'(12'h030) || paddr == AW'(12'h034)) && pwdata[31] |=>
            slot_q[SLOT_CTRL] == INIT_CTRL && slot_q[SLOT_PWD] == INIT_PWD &&
            slot_q[SLOT_TX] == INIT_TX && slot_q[SLOT_RX] == INIT_RX);

    // R6: soft reset leaves status and debug registers alone
    assert_soft_keep_R6: assert property (@(posedge pclk) disable iff (!presetn)
        acc && paddr == AW'(12'h030) && pwdata[31] |=>
            $stable(slot_q[SLOT_STAT]) && $stable(slot_q[SLOT_DBG]) &&
            $stable(slot_q[SLOT_DBG1]));

    // R7: clear alias of control never reloads power-down
    assert_clr_no_soft_R7: assert property (@(posedge pclk) disable iff (!presetn)
        acc && paddr == AW'(12'h038) |=> $stable(slot_q[SLOT_PWD]));

    // R7: toggle of control fires only when bit 31 goes from 0 to 1
    assert_tog_fire_R7: assert property (@(posedge pclk) disable iff (!presetn)
        acc && paddr == AW'(12'h03C) && pwdata[31] && !slot_q[SLOT_CTRL][31] |=>
            slot_q[SLOT_PWD] == INIT_PWD && slot_q[SLOT_CTRL] == INIT_CTRL);

    assert_tog_quiet_R7: assert property (@(posedge pclk) disable iff (!presetn)
        acc && paddr == AW'(12'h03C) && pwdata[31] && slot_q[SLOT_CTRL][31] |=>
            $stable(slot_q[SLOT_PWD]) && !slot_q[SLOT_CTRL][31]);

    // R8: writes to read-only or unmapped words change nothing
    assert_ro_ignore_R8: assert property (@(posedge pclk) disable iff (!presetn)
        acc && (paddr == AW'(12'h060) || paddr == AW'(12'h080) ||
                paddr == AW'(12'h044) || paddr > AW'(12'h080)) |=> $stable(slot_q));

    // R9: partial strobes or misaligned addresses change nothing
    assert_partial_ignore_R9: assert property (@(posedge pclk) disable iff (!presetn)
        psel && penable && pwrite && (pstrb != 4'hF || paddr[1:0] != 2'b00)
            |=> $stable(slot_q));
endmodule

bind phy_ctrl_regbank phy_ctrl_regbank_chk #(.AW(AW)) i_chk (
    .pclk    (pclk),
    .presetn (presetn),
    .psel    (psel),
    .penable (penable),
    .pwrite  (pwrite),
    .paddr   (paddr),
    .pwdata  (pwdata),
    .pstrb   (pstrb),
    .slot_q  (slot_q)
);

// File: tb/test_phy_ctrl_regbank.sv
module test_phy_ctrl_regbank;

    logic        pclk = 1'b0;
    logic        presetn = 1'b0;
    logic        psel = 1'b0;
    logic        penable = 1'b0;
    logic        pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [3:0]  pstrb = '0;
    logic [31:0] prdata;
    logic        pready;
    logic        pslverr;

    int total = 0;
    int bad = 0;

    always #2 pclk = ~pclk;

    phy_ctrl_regbank i_phy_ctrl_regbank (
        .pclk    (pclk),
        .presetn (presetn),
        .psel    (psel),
        .penable (penable),
        .pwrite  (pwrite),
        .paddr   (paddr),
        .pwdata  (pwdata),
        .pstrb   (pstrb),
        .prdata  (prdata),
        .pready  (pready),
        .pslverr (pslverr)
    );

    typedef struct packed {
        logic        wr;
        logic [11:0] addr;
        logic [31:0] data;
        logic [3:0]  strb;
        logic [7:0]  req;
    } vec_t;

    localparam int NVEC = 64;
    // Reads carry the expected value in the data field
    localparam vec_t VEC [NVEC] = '{
        '{1'b0, 12'h000, 32'h001E1C00, 4'hF, 8'd1},  // R1 reset values
        '{1'b0, 12'h010, 32'h10060607, 4'hF, 8'd1},
        '{1'b0, 12'h020, 32'h00000000, 4'hF, 8'd1},
        '{1'b0, 12'h030, 32'hC0200000, 4'hF, 8'd1},
        '{1'b0, 12'h040, 32'h00000000, 4'hF, 8'd1},
        '{1'b0, 12'h050, 32'h7F180000, 4'hF, 8'd1},
        '{1'b0, 12'h060, 32'h00000000, 4'hF, 8'd1},
        '{1'b0, 12'h070, 32'h00001000, 4'hF, 8'd1},
        '{1'b0, 12'h080, 32'h04020000, 4'hF, 8'd1},
        '{1'b1, 12'h000, 32'h12345678, 4'hF, 8'd2},  // R2 direct write
        '{1'b0, 12'h000, 32'h12345678, 4'hF, 8'd2},
        '{1'b1, 12'h004, 32'h0000000F, 4'hF, 8'd3},  // R3 OR alias
        '{1'b0, 12'h008, 32'h1234567F, 4'hF, 8'd4},  // R4 alias read
        '{1'b1, 12'h008, 32'h00000070, 4'hF, 8'd3},  // R3 clear alias
        '{1'b0, 12'h00C, 32'h1234560F, 4'hF, 8'd4},
        '{1'b1, 12'h00C, 32'hFF000000, 4'hF, 8'd3},  // R3 toggle alias
        '{1'b0, 12'h000, 32'hED34560F, 4'hF, 8'd3},
        '{1'b1, 12'h010, 32'hAAAA5555, 4'hF, 8'd2},
        '{1'b1, 12'h018, 32'h0000FFFF, 4'hF, 8'd3},
        '{1'b0, 12'h010, 32'hAAAA0000, 4'hF, 8'd3},
        '{1'b1, 12'h040, 32'hDEADBEEF, 4'hF, 8'd2},
        '{1'b0, 12'h040, 32'hDEADBEEF, 4'hF, 8'd2},
        '{1'b1, 12'h044, 32'hFFFFFFFF, 4'hF, 8'd8},  // R8 status has no alias
        '{1'b0, 12'h040, 32'hDEADBEEF, 4'hF, 8'd8},
        '{1'b0, 12'h044, 32'h00000000, 4'hF, 8'd8},
        '{1'b1, 12'h050, 32'h000000F0, 4'hF, 8'd2},
        '{1'b1, 12'h054, 32'h0F000000, 4'hF, 8'd3},
        '{1'b0, 12'h050, 32'h0F0000F0, 4'hF, 8'd3},
        '{1'b1, 12'h070, 32'h11110000, 4'hF, 8'd2},
        '{1'b1, 12'h07C, 32'h00000001, 4'hF, 8'd3},
        '{1'b0, 12'h074, 32'h11110001, 4'hF, 8'd4},
        '{1'b1, 12'h080, 32'hFFFFFFFF, 4'hF, 8'd8},  // R8 read-only words
        '{1'b0, 12'h080, 32'h04020000, 4'hF, 8'd8},
        '{1'b1, 12'h060, 32'hFFFFFFFF, 4'hF, 8'd8},
        '{1'b0, 12'h060, 32'h00000000, 4'hF, 8'd8},
        '{1'b1, 12'h100, 32'h00001234, 4'hF, 8'd8},
        '{1'b0, 12'h100, 32'h00000000, 4'hF, 8'd8},
        '{1'b1, 12'h020, 32'h000000FF, 4'h3, 8'd9},  // R9 partial strobe
        '{1'b0, 12'h020, 32'h00000000, 4'hF, 8'd9},
        '{1'b1, 12'h022, 32'h000000FF, 4'hF, 8'd9},  // R9 misaligned
        '{1'b0, 12'h020, 32'h00000000, 4'hF, 8'd9},
        '{1'b0, 12'h022, 32'h00000000, 4'hF, 8'd9},
        '{1'b1, 12'h030, 32'h00000005, 4'hF, 8'd2},
        '{1'b0, 12'h030, 32'h00000005, 4'hF, 8'd2},
        '{1'b1, 12'h030, 32'h80000001, 4'hF, 8'd5},  // R5 direct soft reset
        '{1'b0, 12'h030, 32'hC0200000, 4'hF, 8'd5},
        '{1'b0, 12'h000, 32'h001E1C00, 4'hF, 8'd5},
        '{1'b0, 12'h010, 32'h10060607, 4'hF, 8'd5},
        '{1'b0, 12'h040, 32'hDEADBEEF, 4'hF, 8'd6},  // R6 kept
        '{1'b0, 12'h050, 32'h0F0000F0, 4'hF, 8'd6},
        '{1'b0, 12'h070, 32'h11110001, 4'hF, 8'd6},
        '{1'b1, 12'h000, 32'hAAAA0000, 4'hF, 8'd7},
        '{1'b1, 12'h038, 32'h80000000, 4'hF, 8'd7},  // R7 clear: no fire
        '{1'b0, 12'h030, 32'h40200000, 4'hF, 8'd7},
        '{1'b0, 12'h000, 32'hAAAA0000, 4'hF, 8'd7},
        '{1'b1, 12'h03C, 32'h80000000, 4'hF, 8'd7},  // R7 toggle 0->1 fires
        '{1'b0, 12'h000, 32'h001E1C00, 4'hF, 8'd7},
        '{1'b0, 12'h03C, 32'hC0200000, 4'hF, 8'd7},
        '{1'b1, 12'h000, 32'h00000005, 4'hF, 8'd7},
        '{1'b1, 12'h03C, 32'h80000000, 4'hF, 8'd7},  // R7 toggle 1->0 quiet
        '{1'b0, 12'h030, 32'h40200000, 4'hF, 8'd7},
        '{1'b0, 12'h000, 32'h00000005, 4'hF, 8'd7},
        '{1'b1, 12'h034, 32'h80000000, 4'hF, 8'd5},  // R5 OR alias fires
        '{1'b0, 12'h000, 32'h001E1C00, 4'hF, 8'd5}
    };

    task automatic check(input string req, input logic [31:0] got,
                         input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%08h exp=%08h", req, got, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d,
                             input logic [3:0] s);
        @(negedge pclk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1;
        paddr = a; pwdata = d; pstrb = s;
        @(negedge pclk);
        penable = 1'b1;
        @(negedge pclk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d,
                            output logic rdy, output logic err);
        @(negedge pclk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
        @(negedge pclk);
        penable = 1'b1;
        #1;
        d = prdata; rdy = pready; err = pslverr;
        @(negedge pclk);
        psel = 1'b0; penable = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge pclk);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        logic        rdy;
        logic        err;
        repeat (3) @(negedge pclk);
        presetn = 1'b1;

        // Table walk: writes apply, reads compare
        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i].wr) begin
                bus_write(VEC[i].addr, VEC[i].data, VEC[i].strb);
            end else begin
                bus_read(VEC[i].addr, rd, rdy, err);
                check($sformatf("R%0d vec%0d", VEC[i].req, i), rd, VEC[i].data);
            end
        end

        // R10: zero-wait handshake, no error response
        bus_read(12'h030, rd, rdy, err);
        check("R10 pready", {31'd0, rdy}, 32'd1);
        check("R10 pslverr", {31'd0, err}, 32'd0);
        bus_write(12'h050, 32'h00C0FFEE, 4'hF);
        bus_read(12'h058, rd, rdy, err);
        check("R10 write seen next access", rd, 32'h00C0FFEE);

        // R1: hardware reset in the middle of a run restores every slot
        bus_write(12'h020, 32'h0BAD0BAD, 4'hF);
        @(negedge pclk);
        presetn = 1'b0;
        repeat (2) @(negedge pclk);
        presetn = 1'b1;
        bus_read(12'h040, rd, rdy, err);
        check("R1 status after hw reset", rd, 32'h00000000);
        bus_read(12'h050, rd, rdy, err);
        check("R1 debug after hw reset", rd, 32'h7F180000);
        bus_read(12'h070, rd, rdy, err);
        check("R1 debug1 after hw reset", rd, 32'h00001000);
        bus_read(12'h020, rd, rdy, err);
        check("R1 rx after hw reset", rd, 32'h00000000);
        bus_read(12'h030, rd, rdy, err);
        check("R1 ctrl after hw reset", rd, 32'hC0200000);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule